// File: doc/BRIEF.md
# Radix-4 Digit-Reversal Reorder Buffer

This block sits behind a 1024-point radix-4 FFT. The FFT delivers its results in base-4 digit-reversed order. The block turns them back into natural frequency order. Each complex result has a 14-bit real part and a 14-bit imaginary part and comes with a valid strobe.

The block keeps a count of accepted samples. It swaps the count's 2-bit digit groups end for end and uses the result as the write position in one of two sample banks. When the count wraps, that bank holds a complete frame. The bank is then played out in natural order on consecutive cycles, with its own valid strobe. Meanwhile the next frame fills the other bank.

The FFT arithmetic, the twiddle factors and any gain correction are outside this block.

Top module: `digit_reorder_buf`

## Requirements
- R1: After a synchronous active-high reset, `out_valid` and `overflow` are low. `out_valid` stays low until a full frame of 1024 samples has been accepted.
- R2: The arrival count advances only on cycles with `in_valid` high. Idle cycles inside a frame do not change where any sample lands.
- R3: A sample accepted at arrival count c (10 bits) is written to natural position p. Position p is c with its five 2-bit groups in reverse order: c[1:0] goes to p[9:8], c[3:2] to p[7:6], c[5:4] to p[5:4], c[7:6] to p[3:2] and c[9:8] to p[1:0].
- R4: The two bits inside each group keep their order, so this is not a binary bit reversal. For example, count 1 maps to position 256, and count 2 maps to position 512.
- R5: A complete frame is played out as 1024 consecutive `out_valid` cycles carrying positions 0 to 1023 in rising order. The first of these cycles follows the clock edge after the edge that accepted the frame's last sample.
- R6: Frames that arrive back to back, with no idle cycle between them, come out back to back with no gap and no lost or repeated sample.
- R7: `overflow` rises, and stays high until reset, if a frame completes while the other bank still holds unread samples. The new frame is still written. With at most one input sample per cycle this never happens, including the back-to-back case.
- R8: A reset in the middle of a frame discards the partial frame. The next accepted sample is treated as arrival count 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_re | input | 14 | Real part of the input sample |
| in_im | input | 14 | Imaginary part of the input sample |
| out_valid | output | 1 | Output sample strobe |
| out_re | output | 14 | Real part of the output sample, natural order |
| out_im | output | 14 | Imaginary part of the output sample, natural order |
| overflow | output | 1 | Sticky flag: a frame completed over an unread bank |

## Verification
The hardest case to reach is the frame boundary under continuous input. There, the edge that completes frame N+1 is the same edge that releases the bank holding frame N. The bank release and the new completion coincide exactly, so an off-by-one in the release would show up as a false overflow or a one-cycle output gap. The stimulus reaches this edge by driving three frames with no idle cycle between them. The bench then checks that the output run stays unbroken and that `overflow` stays low. Every sample carries a value derived from its natural position and a frame tag, so any misplacement across digit groups or across frames shows up as a data mismatch.

// File: rtl/dr_reorder_pkg.sv
package dr_reorder_pkg;

  // Reverse the order of the 2-bit groups in the low 2*ndig bits of v.
  // Bits inside a group keep their order.
  function automatic logic [31:0] digit_swap(input logic [31:0] v, input int unsigned ndig);
    logic [31:0] r;
    r = '0;
    for (int unsigned k = 0; k < ndig; k++) begin
      r[2*(ndig-1-k) +: 2] = v[2*k +: 2];
    end
    return r;
  endfunction

  typedef enum logic {BANK_A = 1'b0, BANK_B = 1'b1} bank_e;

endpackage

// File: rtl/dr_wr_addr.sv
module dr_wr_addr #(
  parameter int unsigned DIGITS = 5,
  localparam int unsigned AW = 2 * DIGITS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic [AW-1:0] wr_addr,
  output logic          frame_done,
  output logic          wr_bank
);
  import dr_reorder_pkg::*;

  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  logic [AW-1:0] arr_cnt;

  // Digit-group swap built structurally, one 2-bit group per iteration.
  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    assign wr_addr[2*(DIGITS-1-g) +: 2] = arr_cnt[2*g +: 2];
  end

  assign frame_done = in_valid && (arr_cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      arr_cnt <= '0;
      wr_bank <= BANK_A;
    end else begin
      if (in_valid) arr_cnt <= arr_cnt + 1'b1;
      if (frame_done) wr_bank <= ~wr_bank;
    end
  end

  // R2: the count moves only on accepted samples
  a_r2_advance: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> arr_cnt == $past(arr_cnt) + 1'b1);
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(arr_cnt));
  // R3: the structural swap and the package function agree (inverse direction)
  a_r3_map: assert property (@(posedge clk) disable iff (rst)
    AW'(digit_swap(32'(wr_addr), DIGITS)) == arr_cnt);
  // R6: completing a frame moves writes to the other bank
  a_r6_switch: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> wr_bank != $past(wr_bank));

endmodule

// File: rtl/dr_rd_ctrl.sv
module dr_rd_ctrl #(
  parameter int unsigned AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_done,
  input  logic          wr_bank,
  output logic          rd_en,
  output logic          rd_bank,
  output logic [AW-1:0] rd_addr,
  output logic          out_valid,
  output logic          overflow
);
  import dr_reorder_pkg::*;

  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  logic [1:0] full_q, full_n;
  logic       rd_last;
  logic       ovf_evt;
  logic       other_bank;

  assign rd_en      = full_q[rd_bank];
  assign rd_last    = rd_en && (rd_addr == LAST);
  assign other_bank = ~wr_bank;
  // a frame lands while the opposite bank is still unread and not being released
  assign ovf_evt    = frame_done && full_q[other_bank] && !(rd_last && (rd_bank == other_bank));

  always_comb begin
    full_n = full_q;
    if (rd_last)    full_n[rd_bank] = 1'b0;
    if (frame_done) full_n[wr_bank] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q    <= 2'b00;
      rd_bank   <= BANK_A;
      rd_addr   <= '0;
      out_valid <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      full_q    <= full_n;
      out_valid <= rd_en;
      if (rd_en)   rd_addr <= rd_addr + 1'b1;
      if (rd_last) rd_bank <= ~rd_bank;
      if (ovf_evt) overflow <= 1'b1;
    end
  end

  // R7: with one sample per cycle, the drain always keeps up
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst) !ovf_evt);
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst) overflow |=> overflow);
  // R6: a completing frame never lands on a bank that still holds data
  a_r6_no_clobber: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> !full_q[wr_bank]);
  // R5: after the last read of a bank, the next read comes from the other bank
  a_r5_bank_turn: assert property (@(posedge clk) disable iff (rst)
    rd_last |=> rd_bank != $past(rd_bank));
  // R1: output only begins once some bank has been filled
  a_r1_first_out: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(full_q != 2'b00));

endmodule

// File: rtl/dr_pingpong_mem.sv
module dr_pingpong_mem #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 28,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic          wr_bank,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic          rd_bank,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] store [2*DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[{wr_bank, wr_addr}] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= store[{rd_bank, rd_addr}];
  end

endmodule

// File: rtl/digit_reorder_buf.sv
module digit_reorder_buf #(
  parameter int unsigned DATA_W = 14,
  parameter int unsigned DIGITS = 5,
  localparam int unsigned AW = 2 * DIGITS,
  localparam int unsigned SW = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_re,
  input  logic [DATA_W-1:0] in_im,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_re,
  output logic [DATA_W-1:0] out_im,
  output logic              overflow
);
  logic [AW-1:0] wr_addr;
  logic          frame_done;
  logic          wr_bank;
  logic          rd_en;
  logic          rd_bank;
  logic [AW-1:0] rd_addr;
  logic [SW-1:0] rd_data;

  dr_wr_addr #(.DIGITS(DIGITS)) u_wr (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .wr_addr(wr_addr), .frame_done(frame_done), .wr_bank(wr_bank)
  );

  dr_rd_ctrl #(.AW(AW)) u_rd (
    .clk(clk), .rst(rst), .frame_done(frame_done), .wr_bank(wr_bank),
    .rd_en(rd_en), .rd_bank(rd_bank), .rd_addr(rd_addr),
    .out_valid(out_valid), .overflow(overflow)
  );

  dr_pingpong_mem #(.AW(AW), .DW(SW)) u_mem (
    .clk(clk),
    .wr_en(in_valid), .wr_bank(wr_bank), .wr_addr(wr_addr), .wr_data({in_re, in_im}),
    .rd_en(rd_en), .rd_bank(rd_bank), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  assign out_re = rd_data[SW-1:DATA_W];
  assign out_im = rd_data[DATA_W-1:0];

  // R6: while a frame plays out, the writer never fills the bank being read
  a_r6_bank_split: assert property (@(posedge clk) disable iff (rst)
    (in_valid && rd_en) |-> wr_bank != rd_bank);

endmodule

// File: tb/tb_digit_reorder_buf.sv
module tb_digit_reorder_buf;
  localparam int N = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [13:0] in_re = '0, in_im = '0;
  logic out_valid, overflow;
  logic [13:0] out_re, out_im;

  int checks = 0, fails = 0;
  logic [27:0] expq [$];
  int run_len = 0;

  always #2 clk = ~clk;

  digit_reorder_buf dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im), .overflow(overflow)
  );

  // Natural position of arrival count c, computed arithmetically in base 4.
  function automatic int nat_pos(input int c);
    int p = 0, v = c;
    for (int d = 0; d < 5; d++) begin
      p = p * 4 + (v % 4);
      v = v / 4;
    end
    return p;
  endfunction

  function automatic logic [13:0] re_of(input int tag, input int p);
    return 14'((tag * N + p) % 16384);
  endfunction
  function automatic logic [13:0] im_of(input int tag, input int p);
    return 14'((p * 3 + tag * 7) % 16384);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // R2, R3: drive n samples of a frame; an idle cycle every gap_mod samples.
  task automatic drive_samples(input int tag, input int n, input int gap_mod);
    for (int c = 0; c < n; c++) begin
      if (gap_mod > 0 && (c % gap_mod) == gap_mod - 1) begin
        @(negedge clk);
        in_valid = 1'b0;
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_re = re_of(tag, nat_pos(c));
      in_im = im_of(tag, nat_pos(c));
    end
  endtask

  task automatic drive_frame(input int tag, input int gap_mod);
    drive_samples(tag, N, gap_mod);
    for (int p = 0; p < N; p++) expq.push_back({re_of(tag, p), im_of(tag, p)});
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Scoreboard monitor: R3, R4, R5 data order; R5, R6 run length.
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        run_len++;
        if (expq.size() == 0) begin
          check(1'b0, "R1", "unexpected output sample", int'(out_re), -1);
        end else begin
          logic [27:0] e;
          e = expq.pop_front();
          check(out_re == e[27:14], "R3", "out_re", int'(out_re), int'(e[27:14]));
          check(out_im == e[13:0], "R4", "out_im", int'(out_im), int'(e[13:0]));
        end
      end else if (run_len != 0) begin
        check((run_len % N) == 0, "R6", "output run length", run_len, N);
        run_len = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    check(overflow == 1'b0, "R1", "overflow after reset", int'(overflow), 0);

    // R2, R5: frame with idle gaps, then exact output latency
    drive_frame(1, 7);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b0, "R5", "out_valid one edge after last sample", int'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R5", "out_valid two edges after last sample", int'(out_valid), 1);
    idle(N + 20);
    check(expq.size() == 0, "R5", "samples left after frame", expq.size(), 0);

    // R6, R7: three frames back to back
    drive_frame(2, 0);
    drive_frame(3, 0);
    drive_frame(4, 0);
    idle(N + 20);
    check(expq.size() == 0, "R6", "samples left after back-to-back", expq.size(), 0);
    check(overflow == 1'b0, "R7", "overflow after back-to-back", int'(overflow), 0);

    // R8: reset in the middle of a frame discards it
    drive_samples(9, 300, 0);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(out_valid == 1'b0, "R8", "out_valid after mid-frame reset", int'(out_valid), 0);
    check(overflow == 1'b0, "R8", "overflow after mid-frame reset", int'(overflow), 0);
    idle(40);
    check(out_valid == 1'b0, "R1", "no output before a full frame", int'(out_valid), 0);
    drive_frame(5, 11);
    idle(N + 20);
    check(expq.size() == 0, "R8", "samples left after post-reset frame", expq.size(), 0);
    check(overflow == 1'b0, "R7", "overflow at end", int'(overflow), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule